// File: doc/BRIEF.md
# Phase-Accumulator Square-Wave Generator

This block drives one digital output line with a square wave whose frequency is set by a tuning word. It holds a 24-bit accumulator. While the generator runs, the accumulator adds the tuning word once per clock. The top bit of the accumulator, gated by the run state, drives the line. The output frequency is therefore the clock frequency times the tuning word, divided by 2^24.

A command is either a tuning-word write or a stop. The block captures each command in a one-entry staging register and applies it on the next clock edge. The `busy` output is high while a command waits in that register. When a tuning word is applied, the accumulator is preset to half scale. The line therefore rises as the write takes effect, and the wave's phase is tied to the cycle of the write.

A stop freezes the accumulator and holds the line low. The caller presents each command in the clock cycle on which it must act. When the tuning word is not a power of two, the output edges move by one clock from period to period. This jitter is expected and is left as it is.

Top module: `phase_clkgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `line_out` is 0 and `busy` is 0. The stored tuning word, the accumulator and the run state all start at 0.
- R2: A cycle with `ftw_we` or `stop_req` high makes `busy` read 1 in the next cycle. If no further command follows, `busy` reads 0 one cycle after that.
- R3: A tuning word sampled with `ftw_we` high at clock edge k is applied at edge k+1. The accumulator is loaded with 0x800000 at that edge, so `line_out` is 1 after it.
- R4: While running, each later clock edge adds the stored tuning word to the accumulator modulo 2^24. `line_out` equals bit 23 of the accumulator. For example, word 0x400000 gives the line pattern 1,1,0,0 repeating.
- R5: A stop sampled at edge k (with no write in the same cycle) takes effect at edge k+1. From then on `line_out` is 0 and the accumulator is frozen until the next write.
- R6: When `ftw_we` and `stop_req` are high in the same cycle, the write is applied and the stop is discarded.
- R7: A tuning word of 0 leaves the accumulator at 0x800000, so the line stays high.
- R8: A write issued after a stop restarts the wave from the 0x800000 preset, whatever value the accumulator was frozen at.
- R9: A tuning word that is not a power of two produces the plain modulo sum, including its one-cycle edge jitter. No correction is applied.
- R10: Commands on consecutive cycles each replace the staged one. `busy` stays high throughout. Each staged command is applied one edge after it was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ftw_we | input | 1 | Tuning-word write strobe |
| ftw_in | input | 24 | Tuning word to load |
| stop_req | input | 1 | Stop command |
| line_out | output | 1 | Square-wave output line |
| busy | output | 1 | A staged command has not yet been applied |

## Verification
Any error in the accumulator, the stored word or the run state shows up as a wrong `line_out` value. This happens at the latest when the accumulator's top bit next differs from the correct one, which takes at most about 2^24 divided by the tuning word clocks. An error in the staging register shows on `busy` in the very next cycle. An error in the preset or the stop gating shows on the line one edge after the command. The bench therefore compares both outputs against an arithmetic model on every clock, and it also checks short hand-computed sequences.

// File: rtl/phase_clkgen.sv
module phase_clkgen #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ftw_we,
  input  logic [ACC_W-1:0] ftw_in,
  input  logic             stop_req,
  output logic             line_out,
  output logic             busy
);
  localparam logic [ACC_W-1:0] PRESET = {1'b1, {(ACC_W-1){1'b0}}};

  logic             pend_v, pend_stop, run;
  logic [ACC_W-1:0] pend_ftw, ftw_q, acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_stop <= 1'b0;
      pend_ftw  <= '0;
      ftw_q     <= '0;
      acc       <= '0;
      run       <= 1'b0;
    end else begin
      pend_v    <= ftw_we | stop_req;
      pend_stop <= stop_req & ~ftw_we;
      if (ftw_we) pend_ftw <= ftw_in;
      if (pend_v) begin
        if (pend_stop) begin
          run <= 1'b0;
        end else begin
          run   <= 1'b1;
          ftw_q <= pend_ftw;
          acc   <= PRESET;
        end
      end else if (run) begin
        acc <= acc + ftw_q;
      end
    end
  end

  assign line_out = run & acc[ACC_W-1];
  assign busy     = pend_v;
endmodule

module phase_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic ftw_we,
  input logic stop_req,
  input logic line_out,
  input logic busy
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!line_out && !busy)); // R1
  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (ftw_we || stop_req) |=> busy); // R2
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ftw_we && !stop_req) |=> !busy); // R2
  AST_WRITE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    ftw_we |=> ##1 line_out); // R3
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !ftw_we) |=> ##1 !line_out); // R5
endmodule

bind phase_clkgen phase_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ftw_we(ftw_we), .stop_req(stop_req),
  .line_out(line_out), .busy(busy)
);

// File: tb/phase_clkgen_tb.sv
module phase_clkgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ftw_we = 1'b0;
  logic [23:0] ftw_in = '0;
  logic        stop_req = 1'b0;
  logic        line_out, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  phase_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .ftw_we(ftw_we), .ftw_in(ftw_in),
    .stop_req(stop_req), .line_out(line_out), .busy(busy)
  );

  always #10 clk = ~clk;

  // reference model: pending command slot plus integer phase
  bit     m_pv, m_ps, m_run;
  longint m_pw, m_w, m_ph;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_pv = 0; m_ps = 0; m_run = 0; m_pw = 0; m_w = 0; m_ph = 0;
    end else begin
      if (m_pv) begin
        if (m_ps) m_run = 0;
        else begin m_run = 1; m_w = m_pw; m_ph = 64'd8388608; end
      end else if (m_run) begin
        m_ph = (m_ph + m_w) % 64'd16777216;
      end
      m_pv = ftw_we || stop_req;
      m_ps = stop_req && !ftw_we;
      if (ftw_we) m_pw = ftw_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (line_out !== (m_run && m_ph >= 64'd8388608)) begin
        errors++;
        $display("FAIL R4/R9 model line: got %b exp %b", line_out, (m_run && m_ph >= 64'd8388608));
      end
      checks++;
      if (busy !== m_pv) begin
        errors++;
        $display("FAIL R2/R10 model busy: got %b exp %b", busy, m_pv);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b exp %b", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic cmd(input bit we, input logic [23:0] w, input bit st);
    ftw_we = we; ftw_in = w; stop_req = st;
    @(negedge clk);
    ftw_we = 0; stop_req = 0;
  endtask

  initial begin
    repeat (3) tick();
    chk(line_out, 1'b0, "R1 line in reset");
    chk(busy, 1'b0, "R1 busy in reset");
    rst_n = 1;
    tick();
    chk(line_out, 1'b0, "R1 line after reset");
    chk(busy, 1'b0, "R1 busy after reset");

    cmd(1, 24'h400000, 0);
    chk(busy, 1'b1, "R2 busy after write");
    chk(line_out, 1'b0, "R3 not yet applied");
    tick();
    chk(busy, 1'b0, "R2 busy clears");
    chk(line_out, 1'b1, "R3 preset high");
    tick(); chk(line_out, 1'b1, "R4 step1");
    tick(); chk(line_out, 1'b0, "R4 step2");
    tick(); chk(line_out, 1'b0, "R4 step3");
    tick(); chk(line_out, 1'b1, "R4 step4");
    tick(); chk(line_out, 1'b1, "R4 step5");

    cmd(0, 24'h0, 1);
    chk(busy, 1'b1, "R2 busy after stop");
    tick();
    chk(line_out, 1'b0, "R5 stopped low");
    for (int i = 0; i < 8; i++) begin tick(); chk(line_out, 1'b0, "R5 stays low"); end

    cmd(1, 24'h200000, 0);
    tick();
    chk(line_out, 1'b1, "R8 restart from preset");
    tick(); chk(line_out, 1'b1, "R8 phase step1");

    cmd(1, 24'h100000, 1);
    tick();
    chk(line_out, 1'b1, "R6 write wins over stop");
    repeat (4) tick();
    chk(line_out, 1'b1, "R6 still running");

    cmd(1, 24'h0, 0);
    tick();
    for (int i = 0; i < 10; i++) begin tick(); chk(line_out, 1'b1, "R7 zero word holds high"); end

    cmd(1, 24'h300000, 0);
    repeat (60) tick();

    ftw_we = 1; ftw_in = 24'h080000;
    tick();
    ftw_in = 24'h600000;
    tick();
    ftw_we = 0; stop_req = 1;
    tick();
    chk(busy, 1'b1, "R10 busy held across back-to-back");
    stop_req = 0;
    tick();
    chk(busy, 1'b0, "R10 busy clears");
    chk(line_out, 1'b0, "R10 last staged stop applied");
    cmd(1, 24'h555555, 0);
    repeat (80) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule